// File: doc/BRIEF.md
# Ethernet MAC Descriptor Ring Engine

This block keeps the table of frame descriptors for a 10/100 Ethernet MAC and runs both directions over it. Each descriptor has two 32-bit words: a control/status word and a buffer address word. A programmable count splits the table in two. The leading entries form the transmit section. Every entry after them forms the receive section.

The transmit walker waits on the descriptor it currently points at. Once the host marks that descriptor ready, the walker hands its buffer address and byte length to the frame-transmit side and holds the request until a done strobe arrives. It then writes the result flags back into the status word and hands ownership back to the host. The receive side has no handshake: each arriving frame is stored in the current receive descriptor if the host has left it empty, and dropped with a busy indication if not. Completions set interrupt source bits. The host clears those bits by writing ones. A mask register gates them onto a single interrupt line.

The host sees everything through a flat 32-bit register bus. Writes are strobed. Reads are combinational from the address.

Top module: `mac_desc_ring`

## Requirements
- R1: After reset every register and descriptor word reads zero. The register addresses are:
  - mode at 0x000: bit 0 enables receive, bit 1 enables transmit.
  - interrupt sources at 0x004, 7 bits.
  - mask at 0x008, 7 bits.
  - transmit count at 0x020.
  - descriptor i: status word at 0x400+8*i, address word at 0x404+8*i.
  
  Unmapped addresses read zero.
- R2: The transmit count register holds the number of transmit descriptors. A write larger than NDESC stores NDESC. Descriptors 0 to count-1 form the transmit section and the rest form the receive section. When the receive section is empty, arriving frames are ignored.
- R3: While transmit is enabled and the current transmit descriptor has bit 15 (ready) set, tx_req rises one cycle later and stays high until tx_done. The outputs while it is high are:
  - tx_addr: the descriptor's address word.
  - tx_len: status bits 31:16.
  - tx_pad: status bit 12.
  - tx_crc: status bit 11.
- R4: On tx_done during a request, the status word keeps bits 31:16 and 14:9. Bit 15 is cleared. Bits 8:0 take tx_res: bit 0 carrier lost, bit 1 defer, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun. A descriptor without bit 15 set is never sent.
- R5: On rx_valid with receive enabled and the current receive descriptor empty (bit 15 set), the status word changes as follows:
  - bits 31:16 take rx_len.
  - bit 15 is cleared.
  - bits 14:9 are kept.
  - bits 8:0 take rx_flags: bit 0 late collision, 1 CRC, 2 short, 3 too long, 4 dribble, 5 invalid symbol, 6 overrun, 7 miss, 8 control frame.
  
  rx_addr always shows the address word of the current receive descriptor.
- R6: A frame that arrives when the current receive descriptor is not empty is dropped. It sets source bit 4 (busy), leaves the descriptor unchanged and does not move the pointer.
- R7: After a descriptor is used, its pointer goes back to the first entry of its section if status bit 13 (wrap) is set or if the descriptor is the last one of the section. Otherwise the pointer moves to the next entry.
- R8: When the used descriptor has bit 14 set, a completion sets these source bits:
  - Transmit: bit 1 if tx_res has any of bits 0, 2, 3 or 8 set, otherwise bit 0.
  - Receive: bit 3 if rx_flags has any of bits 0-3 or 5-7 set, otherwise bit 2. Bit 6 is also set when rx_flags bit 8 is set.
  
  With bit 14 clear, a completion sets no source bit.
- R9: Writing to 0x004 clears each source bit that is written as one. A source bit set by an event in the same cycle stays set.
- R10: irq is high exactly when some source bit and its mask bit are both set.
- R11: Clearing the transmit enable returns the transmit pointer to descriptor 0 and drops any outstanding request. Clearing the receive enable returns the receive pointer to the first receive descriptor. Frames are ignored while receive is disabled, and tx_done is ignored when no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| tx_req | output | 1 | Transmit request pending |
| tx_addr | output | 32 | Buffer address of the frame to send |
| tx_len | output | 16 | Byte length of the frame to send |
| tx_pad | output | 1 | Pad request of the frame to send |
| tx_crc | output | 1 | CRC append request of the frame to send |
| tx_done | input | 1 | Transmit completion strobe |
| tx_res | input | 9 | Transmit result flags |
| rx_valid | input | 1 | Received frame strobe |
| rx_len | input | 16 | Received byte length, CRC included |
| rx_flags | input | 9 | Received frame flags |
| rx_addr | output | 32 | Buffer address of the current receive descriptor |
| irq | output | 1 | Masked interrupt |

## Verification
The transmit section holds a mix of descriptors: one with the pad flag, one with the CRC flag, one with its interrupt bit clear, and one left unready. The walker must stop exactly at the unready entry. Rotating results (clean, late collision, defer with retries) separate the frame source from the error source, and they show that defer and the retry count are not counted as errors. Receive frames are sent clean, with a CRC error, as control frames and with only a dribble nibble, which separates the three receive source bits. A wrap bit placed before the end of the section, followed by a further frame, makes a drop observable. A re-armed entry placed behind the pointer shows whether the pointer was reset when receive was disabled. Changing the count so that the receive section is empty shows that the split moves.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  // status word fields shared by both sections
  localparam int B_OWN  = 15;
  localparam int B_IEN  = 14;
  localparam int B_WRAP = 13;
  localparam int B_PAD  = 12;
  localparam int B_CRC  = 11;
  // interrupt source bit positions
  localparam int S_TXF  = 0;
  localparam int S_TXE  = 1;
  localparam int S_RXF  = 2;
  localparam int S_RXE  = 3;
  localparam int S_BUSY = 4;
  localparam int S_RXC  = 6;
  localparam int SRC_W  = 7;
  // result flags counted as errors
  localparam logic [8:0] TX_ERR = 9'h10D;
  localparam logic [8:0] RX_ERR = 9'h0EF;
  typedef enum logic {TXS_IDLE, TXS_WAIT} txs_e;
endpackage

// File: rtl/mdr_desc_table.sv
module mdr_desc_table #(
  parameter int NDESC = 16,
  localparam int IW = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic          hw_sel,
  input  logic [IW-1:0] hw_idx,
  input  logic [31:0]   hw_data,
  input  logic          tx_we,
  input  logic [IW-1:0] tx_idx,
  input  logic [31:0]   tx_data,
  input  logic          rx_we,
  input  logic [IW-1:0] rx_idx,
  input  logic [31:0]   rx_data,
  output logic [31:0]   stat_o [NDESC],
  output logic [31:0]   addr_o [NDESC]
);
  for (genvar i = 0; i < NDESC; i++) begin : g_desc
    logic [31:0] st_q, st_d, ad_q, ad_d;
    logic        st_en, ad_en;

    // engine writes win over host writes to the same word
    always_comb begin
      st_d  = st_q;
      ad_d  = ad_q;
      st_en = 1'b0;
      ad_en = 1'b0;
      if (hw_en && hw_idx == IW'(i)) begin
        if (hw_sel) begin ad_d = hw_data; ad_en = 1'b1; end
        else        begin st_d = hw_data; st_en = 1'b1; end
      end
      if (tx_we && tx_idx == IW'(i)) begin st_d = tx_data; st_en = 1'b1; end
      if (rx_we && rx_idx == IW'(i)) begin st_d = rx_data; st_en = 1'b1; end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        ad_q <= '0;
      end else begin
        if (st_en) st_q <= st_d;
        if (ad_en) ad_q <= ad_d;
      end
    end

    assign stat_o[i] = st_q;
    assign addr_o[i] = ad_q;
  end
endmodule

// File: rtl/mdr_tx_walker.sv
module mdr_tx_walker import mdr_pkg::*; #(
  parameter int NDESC = 16,
  localparam int PW = $clog2(NDESC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic [PW-1:0] tx_num,
  input  logic [31:0]   cur_stat,
  input  logic          tx_done,
  input  logic [8:0]    tx_res,
  output logic [PW-1:0] ptr,
  output logic          req,
  output logic          wb_en,
  output logic [31:0]   wb_data,
  output logic          set_f,
  output logic          set_e
);
  txs_e          st_q, st_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          last, err;

  assign req     = (st_q == TXS_WAIT);
  assign wb_en   = req && tx_en && tx_done;
  assign wb_data = {cur_stat[31:16], 1'b0, cur_stat[14:9], tx_res};
  assign err     = |(tx_res & TX_ERR);
  assign set_f   = wb_en && cur_stat[B_IEN] && !err;
  assign set_e   = wb_en && cur_stat[B_IEN] && err;
  assign last    = cur_stat[B_WRAP] || (ptr_q == tx_num - 1'b1);
  assign ptr     = ptr_q;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (!tx_en) begin
      st_d  = TXS_IDLE;
      ptr_d = '0;
    end else if (st_q == TXS_IDLE) begin
      if (ptr_q < tx_num && cur_stat[B_OWN]) st_d = TXS_WAIT;
    end else if (tx_done) begin
      st_d  = TXS_IDLE;
      ptr_d = last ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXS_IDLE;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/mdr_rx_filler.sv
module mdr_rx_filler import mdr_pkg::*; #(
  parameter int NDESC = 16,
  localparam int PW = $clog2(NDESC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [PW-1:0] tx_num,
  input  logic [15:9]   cur_ctl,
  input  logic          rx_valid,
  input  logic [15:0]   rx_len,
  input  logic [8:0]    rx_flags,
  output logic [PW-1:0] ptr,
  output logic          in_rng,
  output logic          wb_en,
  output logic [31:0]   wb_data,
  output logic          set_f,
  output logic          set_e,
  output logic          set_c,
  output logic          set_busy
);
  localparam logic [PW-1:0] N_P = PW'(NDESC);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          take, last, err;

  assign in_rng   = ptr_q < N_P;
  assign take     = rx_en && rx_valid && in_rng;
  assign wb_en    = take && cur_ctl[B_OWN];
  assign set_busy = take && !cur_ctl[B_OWN];
  assign wb_data  = {rx_len, 1'b0, cur_ctl[14:9], rx_flags};
  assign err      = |(rx_flags & RX_ERR);
  assign set_f    = wb_en && cur_ctl[B_IEN] && !err;
  assign set_e    = wb_en && cur_ctl[B_IEN] && err;
  assign set_c    = wb_en && cur_ctl[B_IEN] && rx_flags[8];
  assign last     = cur_ctl[B_WRAP] || (ptr_q == N_P - 1'b1);
  assign ptr      = ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (!rx_en)     ptr_d = tx_num;
    else if (wb_en) ptr_d = last ? tx_num : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/mdr_irq_regs.sv
module mdr_irq_regs import mdr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_d,
  input  logic [SRC_W-1:0] set_bits,
  output logic [SRC_W-1:0] src_q,
  output logic [SRC_W-1:0] mask_q,
  output logic             irq
);
  logic [SRC_W-1:0] src_d;

  // a set in the same cycle overrides the clear
  assign src_d = (src_q & ~(clr_en ? clr_bits : '0)) | set_bits;
  assign irq   = |(src_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q <= src_d;
      if (mask_we) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/mac_desc_ring.sv
module mac_desc_ring import mdr_pkg::*; #(
  parameter int NDESC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [11:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_req,
  output logic [31:0] tx_addr,
  output logic [15:0] tx_len,
  output logic        tx_pad,
  output logic        tx_crc,
  input  logic        tx_done,
  input  logic [8:0]  tx_res,
  input  logic        rx_valid,
  input  logic [15:0] rx_len,
  input  logic [8:0]  rx_flags,
  output logic [31:0] rx_addr,
  output logic        irq
);
  localparam int IW = $clog2(NDESC);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] N_P = PW'(NDESC);

  logic [1:0]       mode_q, mode_d;
  logic [PW-1:0]    txn_q, txn_d;
  logic             wr_mode, wr_src, wr_mask, wr_txn, desc_hit;
  logic [IW-1:0]    hidx;
  logic [31:0]      stat_a [NDESC];
  logic [31:0]      addr_a [NDESC];
  logic [PW-1:0]    tx_ptr, rx_ptr;
  logic [31:0]      tx_cur, rx_cur, tx_wb, rx_wb;
  logic             tx_wb_en, rx_wb_en, rx_in;
  logic             s_txf, s_txe, s_rxf, s_rxe, s_rxc, s_busy;
  logic [SRC_W-1:0] src_q, mask_q, set_bits;

  assign wr_mode  = host_we && host_addr == 12'h000;
  assign wr_src   = host_we && host_addr == 12'h004;
  assign wr_mask  = host_we && host_addr == 12'h008;
  assign wr_txn   = host_we && host_addr == 12'h020;
  assign desc_hit = host_addr[11:10] == 2'b01 && host_addr[1:0] == 2'b00 &&
                    {1'b0, host_addr[9:3]} < 8'(NDESC);
  assign hidx     = host_addr[3 +: IW];

  always_comb begin
    mode_d = host_wdata[1:0];
    txn_d  = (host_wdata > 32'(NDESC)) ? N_P : host_wdata[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      txn_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_txn)  txn_q  <= txn_d;
    end
  end

  mdr_desc_table #(.NDESC(NDESC)) u_tab (
    .clk, .rst_n,
    .hw_en(host_we && desc_hit), .hw_sel(host_addr[2]), .hw_idx(hidx), .hw_data(host_wdata),
    .tx_we(tx_wb_en), .tx_idx(tx_ptr[IW-1:0]), .tx_data(tx_wb),
    .rx_we(rx_wb_en), .rx_idx(rx_ptr[IW-1:0]), .rx_data(rx_wb),
    .stat_o(stat_a), .addr_o(addr_a)
  );

  assign tx_cur = (tx_ptr < N_P) ? stat_a[tx_ptr[IW-1:0]] : '0;
  assign rx_cur = rx_in ? stat_a[rx_ptr[IW-1:0]] : '0;

  mdr_tx_walker #(.NDESC(NDESC)) u_tx (
    .clk, .rst_n, .tx_en(mode_q[1]), .tx_num(txn_q), .cur_stat(tx_cur),
    .tx_done, .tx_res, .ptr(tx_ptr), .req(tx_req), .wb_en(tx_wb_en),
    .wb_data(tx_wb), .set_f(s_txf), .set_e(s_txe)
  );

  mdr_rx_filler #(.NDESC(NDESC)) u_rx (
    .clk, .rst_n, .rx_en(mode_q[0]), .tx_num(txn_q), .cur_ctl(rx_cur[15:9]),
    .rx_valid, .rx_len, .rx_flags, .ptr(rx_ptr), .in_rng(rx_in),
    .wb_en(rx_wb_en), .wb_data(rx_wb), .set_f(s_rxf), .set_e(s_rxe),
    .set_c(s_rxc), .set_busy(s_busy)
  );

  always_comb begin
    set_bits         = '0;
    set_bits[S_TXF]  = s_txf;
    set_bits[S_TXE]  = s_txe;
    set_bits[S_RXF]  = s_rxf;
    set_bits[S_RXE]  = s_rxe;
    set_bits[S_BUSY] = s_busy;
    set_bits[S_RXC]  = s_rxc;
  end

  mdr_irq_regs u_irq (
    .clk, .rst_n, .clr_en(wr_src), .clr_bits(host_wdata[SRC_W-1:0]),
    .mask_we(wr_mask), .mask_d(host_wdata[SRC_W-1:0]), .set_bits,
    .src_q, .mask_q, .irq
  );

  assign tx_addr = (tx_ptr < N_P) ? addr_a[tx_ptr[IW-1:0]] : '0;
  assign tx_len  = tx_cur[31:16];
  assign tx_pad  = tx_cur[B_PAD];
  assign tx_crc  = tx_cur[B_CRC];
  assign rx_addr = rx_in ? addr_a[rx_ptr[IW-1:0]] : '0;

  always_comb begin
    host_rdata = '0;
    if (desc_hit)                    host_rdata = host_addr[2] ? addr_a[hidx] : stat_a[hidx];
    else if (host_addr == 12'h000)   host_rdata = 32'(mode_q);
    else if (host_addr == 12'h004)   host_rdata = 32'(src_q);
    else if (host_addr == 12'h008)   host_rdata = 32'(mask_q);
    else if (host_addr == 12'h020)   host_rdata = 32'(txn_q);
  end
endmodule

// File: rtl/mdr_checker.sv
module mdr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic       tx_req,
  input logic       tx_done,
  input logic       rx_valid,
  input logic       rx_in,
  input logic       rx_own,
  input logic [6:0] src,
  input logic [6:0] mask,
  input logic       irq
);
  // R3: a pending request stays until its done strobe
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done && tx_en |=> tx_req);
  // R4: a done strobe retires the request
  a_r4_done_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> !tx_req);
  // R11: disabling transmit drops the request
  a_r11_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_req);
  // R6: a frame hitting a full descriptor raises busy
  a_r6_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_valid && rx_in && !rx_own |=> src[4]);
  // R10: a fully masked source set never reaches the line
  a_r10_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 7'd0) |-> !irq);
endmodule

bind mac_desc_ring mdr_checker u_chk (
  .clk, .rst_n, .tx_en(mode_q[1]), .rx_en(mode_q[0]), .tx_req, .tx_done,
  .rx_valid, .rx_in, .rx_own(rx_cur[15]), .src(src_q), .mask(mask_q), .irq
);

// File: tb/sim_mac_desc_ring.sv
`timescale 1ns/1ps
module sim_mac_desc_ring;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_req, tx_pad, tx_crc, irq;
  logic [31:0] tx_addr, rx_addr;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0;
  logic [8:0]  tx_res = '0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_len = '0;
  logic [8:0]  rx_flags = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mac_desc_ring #(.NDESC(N)) u0 (.*);

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_stat [N];
  logic [31:0] m_addr [N];
  logic [1:0]  m_mode;
  logic [6:0]  m_src, m_mask;
  int          m_txn, m_tptr, m_rptr;
  bit          m_tbusy;

  function automatic logic [31:0] mread(logic [11:0] a);
    if (a == 12'h000) return 32'(m_mode);
    if (a == 12'h004) return 32'(m_src);
    if (a == 12'h008) return 32'(m_mask);
    if (a == 12'h020) return 32'(m_txn);
    if (a >= 12'h400 && int'(a) < 'h400 + 8 * N && a[1:0] == 2'b00)
      return a[2] ? m_addr[(int'(a) - 'h400) / 8] : m_stat[(int'(a) - 'h400) / 8];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_stat[i]) begin m_stat[i] = '0; m_addr[i] = '0; end
      m_mode = 0; m_src = 0; m_mask = 0; m_txn = 0; m_tptr = 0; m_rptr = 0; m_tbusy = 0;
    end else begin
      logic [31:0] o_stat [N];
      logic [1:0]  o_mode;
      int          o_txn;
      logic [6:0]  setb, clrb;
      logic [31:0] s;
      o_stat = m_stat; o_mode = m_mode; o_txn = m_txn;
      setb = 0; clrb = 0;
      if (host_we) begin
        if (host_addr == 12'h000) m_mode = host_wdata[1:0];
        else if (host_addr == 12'h004) clrb = host_wdata[6:0];
        else if (host_addr == 12'h008) m_mask = host_wdata[6:0];
        else if (host_addr == 12'h020) m_txn = (host_wdata > N) ? N : int'(host_wdata);
        else if (host_addr >= 12'h400 && int'(host_addr) < 'h400 + 8 * N && host_addr[1:0] == 0) begin
          if (host_addr[2]) m_addr[(int'(host_addr) - 'h400) / 8] = host_wdata;
          else              m_stat[(int'(host_addr) - 'h400) / 8] = host_wdata;
        end
      end
      // transmit side (R3, R4, R7, R8, R11)
      if (!o_mode[1]) begin
        m_tbusy = 0; m_tptr = 0;
      end else if (m_tbusy) begin
        if (tx_done) begin
          s = o_stat[m_tptr];
          m_stat[m_tptr] = {s[31:16], 1'b0, s[14:9], tx_res};
          if (s[14]) begin
            if (tx_res[0] || tx_res[2] || tx_res[3] || tx_res[8]) setb[1] = 1;
            else setb[0] = 1;
          end
          m_tptr = (s[13] || m_tptr == o_txn - 1) ? 0 : m_tptr + 1;
          m_tbusy = 0;
        end
      end else if (m_tptr < o_txn && o_stat[m_tptr][15]) begin
        m_tbusy = 1;
      end
      // receive side (R5, R6, R7, R8, R11)
      if (!o_mode[0]) begin
        m_rptr = o_txn;
      end else if (rx_valid && m_rptr < N) begin
        s = o_stat[m_rptr];
        if (s[15]) begin
          m_stat[m_rptr] = {rx_len, 1'b0, s[14:9], rx_flags};
          if (s[14]) begin
            if ((rx_flags & 9'h0EF) != 0) setb[3] = 1;
            else setb[2] = 1;
            if (rx_flags[8]) setb[6] = 1;
          end
          m_rptr = (s[13] || m_rptr == N - 1) ? o_txn : m_rptr + 1;
        end else begin
          setb[4] = 1;
        end
      end
      m_src = (m_src & ~clrb) | setb;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R3", "tx_req", 32'(tx_req), 32'(m_tbusy));
      if (m_tbusy) begin
        chk("R3", "tx_addr", tx_addr, m_addr[m_tptr]);
        chk("R3", "tx_len", 32'(tx_len), 32'(m_stat[m_tptr][31:16]));
        chk("R3", "tx_pad", 32'(tx_pad), 32'(m_stat[m_tptr][12]));
        chk("R3", "tx_crc", 32'(tx_crc), 32'(m_stat[m_tptr][11]));
      end
      chk("R5", "rx_addr", rx_addr, (m_rptr < N) ? m_addr[m_rptr] : 32'h0);
      chk("R10", "irq", 32'(irq), 32'(|(m_src & m_mask)));
      chk("R1", "host_rdata", host_rdata, mread(host_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [11:0] dst(int i); return 12'(32'h400 + 8 * i); endfunction
  function automatic logic [11:0] dad(int i); return 12'(32'h404 + 8 * i); endfunction

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic hw(logic [11:0] a, logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic peek(logic [11:0] a, string tag);
    @(negedge clk); host_addr = a; #3;
    chk(tag, "readback", host_rdata, mread(a));
  endtask

  task automatic rxf(logic [15:0] len, logic [8:0] fl);
    @(negedge clk); rx_valid = 1; rx_len = len; rx_flags = fl;
    @(negedge clk); rx_valid = 0;
  endtask

  // transmit responder: done three cycles into each request, rotating results
  initial begin
    int wcnt = 0;
    int k = 0;
    forever begin
      @(negedge clk);
      if (tx_done) tx_done = 0;
      else if (tx_req) begin
        wcnt++;
        if (wcnt == 3) begin
          tx_done = 1;
          case (k % 3)
            0: tx_res = 9'h000;
            1: tx_res = 9'h004;
            default: tx_res = 9'h022;
          endcase
          k++;
          wcnt = 0;
        end
      end else wcnt = 0;
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    peek(12'h000, "R1"); peek(12'h004, "R1"); peek(12'h008, "R1");
    peek(12'h020, "R1"); peek(dst(0), "R1"); peek(dad(3), "R1"); peek(12'h7FC, "R1");
    // R2 clamp and split
    hw(12'h020, 300); peek(12'h020, "R2");
    hw(12'h020, 4);   peek(12'h020, "R2");
    hw(12'h008, 32'h7F);
    // transmit descriptors
    hw(dad(0), 32'h1000); hw(dst(0), {16'd60, 16'hD000});
    hw(dad(1), 32'h1100); hw(dst(1), {16'd100, 16'hC800});
    hw(dad(2), 32'h1200); hw(dst(2), {16'd80, 16'h8000});
    hw(dad(3), 32'h1300); hw(dst(3), {16'd70, 16'h4000});
    // receive descriptors, wrap on the third
    for (int i = 4; i < 8; i++) hw(dad(i), 32'h2000 + 32'(i) * 32'h100);
    hw(dst(4), 32'hC000); hw(dst(5), 32'hC000); hw(dst(6), 32'hE000); hw(dst(7), 32'hC000);
    hw(12'h000, 3);
    idle(30);
    peek(dst(0), "R4"); peek(dst(1), "R4"); peek(dst(2), "R4"); peek(dst(3), "R4");
    peek(12'h004, "R8");
    hw(12'h004, 32'h3); peek(12'h004, "R9");
    // receive frames
    rxf(64, 9'h000); rxf(70, 9'h002); rxf(80, 9'h100);
    peek(dst(4), "R5"); peek(dst(5), "R5"); peek(dst(6), "R5"); peek(12'h004, "R8");
    rxf(90, 9'h000);   // wrapped back onto a full entry
    peek(12'h004, "R6"); peek(dst(4), "R6"); peek(dst(7), "R7");
    hw(dst(4), 32'hC000);
    rxf(66, 9'h010);   // dribble only counts as a clean frame
    peek(dst(4), "R5"); peek(12'h004, "R8");
    rxf(67, 9'h000);   // pointer moved on to the full entry 5
    peek(dst(5), "R7"); peek(12'h004, "R6");
    hw(12'h004, 32'h7F); peek(12'h004, "R9");
    hw(12'h008, 32'h0); rxf(68, 9'h000); peek(12'h004, "R10");
    hw(12'h008, 32'h10); idle(2);
    // stray done strobe
    @(negedge clk); #1 tx_done = 1;
    idle(3); peek(dst(3), "R11");
    // disable both directions, frame is ignored
    hw(12'h000, 0);
    hw(dst(5), 32'hC000);
    rxf(71, 9'h000); peek(dst(5), "R11");
    hw(dst(0), {16'd61, 16'hC000});
    hw(12'h000, 3);
    idle(12);
    peek(dst(0), "R11");
    rxf(72, 9'h000); peek(dst(5), "R11"); peek(12'h004, "R11");
    // empty receive section
    hw(12'h020, 16); hw(12'h000, 0); hw(12'h004, 32'h7F); hw(12'h000, 3);
    rxf(73, 9'h000); peek(12'h004, "R2"); peek(dst(5), "R2");
    idle(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule